// File: doc/BRIEF.md
# Banked Scratchpad Conflict Scheduler

This block sits in front of a scratchpad made of 32 banks that are each one 32-bit word wide. It takes one read request for a whole warp. The request has up to 32 lanes, and each lane carries an active flag and a byte address. The block splits the request into a series of steps. In each step, no bank is asked for more than one word. For each step it drives a bank enable and a row (the word index inside the bank) for every bank, and it marks which lanes that step serves.

Consecutive 32-bit words go to consecutive banks. A lane's bank is therefore the word address modulo 32, and its row is the word address divided by 32. Lanes only have to wait for one another when they want different words in the same bank. Lanes that touch any byte of the same word are served together from that single bank read. When the final step is on the ports, the block raises a done pulse and reports how many steps carried data. It accepts a new warp request only once it has returned to idle after that pulse.

Top module: `bank_conflict_sched`

## Requirements
- R1: For an active lane with byte address A, the bank is bits [6:2] of A, which is (A/4) mod 32. The row is bits [15:7] of A, which is A/128. A bank that is enabled in a step drives the row of the word it serves on its 9-bit slice of `bank_row`, in slice b*9 +: 9.
- R2: Each bank reads at most one word per step. `bank_en` and `lane_served` are all zero whenever `step_valid` is low, and any step that serves a lane enables at least one bank.
- R3: In a step, every pending lane whose word matches the word its bank reads is served in that step. This includes lanes with different byte offsets inside the same word.
- R4: In each step, every bank serves the word requested by its lowest-numbered lane that has not yet been served.
- R5: Every active lane is served in exactly one step of its warp. A lane whose active bit is 0 is never served.
- R6: `cycles`, which is valid while `done` is high, equals the largest number of distinct words requested from any one bank. A conflict-free warp takes 1 step, a 2-word stride takes 2 steps, and a 32-word stride takes 32 steps.
- R7: Steps appear on consecutive cycles, starting with the cycle after a request is accepted. `done` is high only on the final step, and `busy` is low on the cycle after it.
- R8: A request is accepted only when `start` is high while `busy` is low. A `start` seen while busy is ignored, and this includes one seen on the `done` cycle.
- R9: A warp with no active lanes takes one step. That step serves no lanes, has `done` high and reports `cycles` as 0.
- R10: After a synchronous active-high reset, `busy`, `step_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| lane_act | input | 32 | Active flag per lane |
| lane_addr | input | 512 | Byte address per lane, lane l in bits l*16 +: 16 |
| busy | output | 1 | Request in progress |
| step_valid | output | 1 | Current step outputs are valid |
| bank_en | output | 32 | Bank reads a word this step |
| bank_row | output | 288 | Row per bank, bank b in bits b*9 +: 9 |
| lane_served | output | 32 | Lanes whose data comes out of this step |
| done | output | 1 | Final step of the warp |
| cycles | output | 6 | Steps that served lanes, valid with done |

## Verification
A wrong pending mask or a wrong captured address shows at the ports in the very step it affects. The served set, the enabled banks or a bank's row then disagree with an independent step-by-step model of the lowest-lane policy. A lost or double grant shows by the done step at the latest: `done` comes early or late, or `cycles` disagrees with the distinct-word count per bank. A request that is wrongly accepted while busy changes the very next step's served set, or leaves `busy` high after `done`.

// File: rtl/bank_sched_pkg.sv
package bank_sched_pkg;
    parameter int NUM_LANES = 32;
    parameter int NUM_BANKS = 32;
    parameter int ADDR_W    = 16;

    localparam int WORD_OFS = 2;
    localparam int BANK_W   = $clog2(NUM_BANKS);
    localparam int ROW_W    = ADDR_W - WORD_OFS - BANK_W;
    localparam int CNT_W    = $clog2(NUM_LANES + 1);

    // word location: row in the upper bits, bank in the lower bits
    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
    } word_loc_t;

    function automatic word_loc_t word_of(input logic [ADDR_W-WORD_OFS-1:0] waddr);
        return word_loc_t'(waddr);
    endfunction
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
    import bank_sched_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [NUM_LANES-1:0]        lane_act,
    input  logic [NUM_LANES*ADDR_W-1:0] lane_addr,
    input  logic [NUM_LANES-1:0]        grant,
    output logic                        busy,
    output logic                        last,
    output logic [NUM_LANES-1:0]        pending,
    output word_loc_t                   locs [NUM_LANES],
    output logic [CNT_W-1:0]            step_cnt
);
    logic [NUM_LANES*WORD_OFS-1:0] unused_byte_ofs;
    logic                          accept;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_ofs
        assign unused_byte_ofs[l*WORD_OFS +: WORD_OFS] = lane_addr[l*ADDR_W +: WORD_OFS];
    end

    assign accept = start && !busy;
    assign last   = (pending & ~grant) == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            pending  <= '0;
            step_cnt <= '0;
        end else if (accept) begin
            busy     <= 1'b1;
            pending  <= lane_act;
            step_cnt <= '0;
            for (int l = 0; l < NUM_LANES; l++)
                locs[l] <= word_of(lane_addr[l*ADDR_W+WORD_OFS +: ADDR_W-WORD_OFS]);
        end else if (busy) begin
            pending  <= pending & ~grant;
            step_cnt <= step_cnt + CNT_W'(|grant);
            if (last)
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/bank_pick.sv
module bank_pick
    import bank_sched_pkg::*;
(
    input  logic [NUM_LANES-1:0] pending,
    input  word_loc_t            locs [NUM_LANES],
    output logic [NUM_BANKS-1:0] sel_en,
    output logic [ROW_W-1:0]     sel_row [NUM_BANKS]
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // scan high to low so the lowest pending lane wins
        always_comb begin
            sel_en[b]  = 1'b0;
            sel_row[b] = '0;
            for (int l = NUM_LANES - 1; l >= 0; l--) begin
                if (pending[l] && locs[l].bank == BANK_W'(b)) begin
                    sel_en[b]  = 1'b1;
                    sel_row[b] = locs[l].row;
                end
            end
        end
    end
endmodule

// File: rtl/lane_grant.sv
module lane_grant
    import bank_sched_pkg::*;
(
    input  logic [NUM_LANES-1:0] pending,
    input  word_loc_t            locs [NUM_LANES],
    input  logic [NUM_BANKS-1:0] sel_en,
    input  logic [ROW_W-1:0]     sel_row [NUM_BANKS],
    output logic [NUM_LANES-1:0] grant
);
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign grant[l] = pending[l] && sel_en[locs[l].bank]
                          && (sel_row[locs[l].bank] == locs[l].row);
    end
endmodule

// File: rtl/bank_conflict_sched.sv
module bank_conflict_sched
    import bank_sched_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [NUM_LANES-1:0]         lane_act,
    input  logic [NUM_LANES*ADDR_W-1:0]  lane_addr,
    output logic                         busy,
    output logic                         step_valid,
    output logic [NUM_BANKS-1:0]         bank_en,
    output logic [NUM_BANKS*ROW_W-1:0]   bank_row,
    output logic [NUM_LANES-1:0]         lane_served,
    output logic                         done,
    output logic [CNT_W-1:0]             cycles
);
    logic [NUM_LANES-1:0] pending;
    logic [NUM_LANES-1:0] grant;
    logic [NUM_BANKS-1:0] sel_en;
    logic [ROW_W-1:0]     sel_row [NUM_BANKS];
    word_loc_t            locs [NUM_LANES];
    logic [CNT_W-1:0]     step_cnt;
    logic                 last;

    sched_ctrl i_ctrl (
        .clk(clk), .rst(rst), .start(start), .lane_act(lane_act),
        .lane_addr(lane_addr), .grant(grant), .busy(busy), .last(last),
        .pending(pending), .locs(locs), .step_cnt(step_cnt)
    );

    bank_pick i_pick (
        .pending(pending), .locs(locs), .sel_en(sel_en), .sel_row(sel_row)
    );

    lane_grant i_grant (
        .pending(pending), .locs(locs), .sel_en(sel_en), .sel_row(sel_row),
        .grant(grant)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_row
        assign bank_row[b*ROW_W +: ROW_W] = busy ? sel_row[b] : '0;
    end

    assign step_valid  = busy;
    assign bank_en     = busy ? sel_en : '0;
    assign lane_served = busy ? grant : '0;
    assign done        = busy && last;
    assign cycles      = step_cnt + CNT_W'(|grant);
endmodule

// File: rtl/sched_chk.sv
module sched_chk
    import bank_sched_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 step_valid,
    input logic                 done,
    input logic [NUM_BANKS-1:0] bank_en,
    input logic [NUM_LANES-1:0] lane_served,
    input logic [CNT_W-1:0]     cycles
);
    logic [NUM_LANES-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst || (start && !busy)) seen <= '0;
        else                         seen <= seen | lane_served;
    end

    // R5
    no_reserve_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_served & seen) == '0);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !step_valid |-> (lane_served == '0 && bank_en == '0));
    // R2
    served_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_served != '0) |-> (bank_en != '0));
    // R7
    done_in_step_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> step_valid);
    // R7
    done_ends_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
    // R8
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R6
    cycles_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles <= CNT_W'(NUM_LANES)));
endmodule

bind bank_conflict_sched sched_chk i_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .step_valid(step_valid),
    .done(done), .bank_en(bank_en), .lane_served(lane_served), .cycles(cycles)
);

// File: tb/test_bank_conflict_sched.sv
module test_bank_conflict_sched;
    import bank_sched_pkg::*;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic                        start = 1'b0;
    logic [NUM_LANES-1:0]        lane_act = '0;
    logic [NUM_LANES*ADDR_W-1:0] lane_addr = '0;
    logic                        busy, step_valid, done;
    logic [NUM_BANKS-1:0]        bank_en;
    logic [NUM_BANKS*ROW_W-1:0]  bank_row;
    logic [NUM_LANES-1:0]        lane_served;
    logic [CNT_W-1:0]            cycles;

    int n_tests = 0;
    int n_fail  = 0;
    int clk_cnt = 0;

    always #2 clk = ~clk;

    bank_conflict_sched i_bank_conflict_sched (
        .clk(clk), .rst(rst), .start(start), .lane_act(lane_act),
        .lane_addr(lane_addr), .busy(busy), .step_valid(step_valid),
        .bank_en(bank_en), .bank_row(bank_row), .lane_served(lane_served),
        .done(done), .cycles(cycles)
    );

    // vector: {base byte address, byte stride, active mask}
    localparam int NV = 10;
    localparam logic [63:0] VEC [NV] = '{
        {16'h0000, 16'd4,   32'hFFFF_FFFF},
        {16'h0000, 16'd8,   32'hFFFF_FFFF},
        {16'h0000, 16'd128, 32'hFFFF_FFFF},
        {16'h0040, 16'd0,   32'hFFFF_FFFF},
        {16'h0000, 16'd1,   32'hFFFF_FFFF},
        {16'h0000, 16'd12,  32'hFFFF_FFFF},
        {16'h0000, 16'd16,  32'hFFFF_FFFF},
        {16'h0100, 16'd128, 32'hAAAA_AAAA},
        {16'h0000, 16'd128, 32'h0000_0000},
        {16'h0002, 16'd4,   32'hFFFF_FFFF}
    };
    localparam int EXP_CYC [NV] = '{1, 2, 32, 1, 1, 1, 4, 16, 0, 1};

    logic [ADDR_W-1:0]    m_addr [NUM_LANES];
    logic [NUM_LANES-1:0] m_act;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int max_distinct();
        int best = 0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            int n = 0;
            for (int l = 0; l < NUM_LANES; l++) begin
                bit fresh = m_act[l] && (int'(m_addr[l][6:2]) == b);
                for (int k = 0; k < l; k++)
                    if (m_act[k] && m_addr[k][15:2] == m_addr[l][15:2]) fresh = 0;
                if (fresh) n++;
            end
            if (n > best) best = n;
        end
        return best;
    endfunction

    // poke >= 0: drive a foreign start at that step number (R8)
    task automatic run_warp(input int exp_cyc, input int poke, input string tag);
        logic [NUM_LANES-1:0] pend;
        int steps = 0;
        bit fin = 0;
        @(negedge clk);
        start    = 1'b1;
        lane_act = m_act;
        for (int l = 0; l < NUM_LANES; l++) lane_addr[l*ADDR_W +: ADDR_W] = m_addr[l];
        @(negedge clk);
        start = 1'b0;
        pend  = m_act;
        while (!fin && steps < 40) begin
            logic [NUM_LANES-1:0] e_srv = '0;
            logic [NUM_BANKS-1:0] e_en  = '0;
            logic [ROW_W-1:0]     e_row [NUM_BANKS];
            int mis = 0;
            if (steps == poke || steps == poke + 1) begin
                start     = (steps == poke);
                lane_act  = '1;
                lane_addr = '0;
            end
            for (int b = 0; b < NUM_BANKS; b++) e_row[b] = '0;
            for (int l = 0; l < NUM_LANES; l++) begin
                int b = int'(m_addr[l][6:2]);
                if (pend[l] && !e_en[b]) begin
                    e_en[b]  = 1'b1;
                    e_row[b] = m_addr[l][15:7];
                end
            end
            for (int l = 0; l < NUM_LANES; l++) begin
                int b = int'(m_addr[l][6:2]);
                if (pend[l] && e_row[b] == m_addr[l][15:7]) e_srv[l] = 1'b1;
            end
            pend = pend & ~e_srv;
            fin  = (pend == '0);
            for (int b = 0; b < NUM_BANKS; b++)
                if (e_en[b] && bank_row[b*ROW_W +: ROW_W] != e_row[b]) mis++;
            chk(step_valid == 1'b1, {tag, " R7 step_valid"}, step_valid, 1);
            chk(lane_served == e_srv, {tag, " R3/R4/R5 lane_served"}, lane_served, e_srv);
            chk(bank_en == e_en, {tag, " R2 bank_en"}, bank_en, e_en);
            chk(mis == 0, {tag, " R1 bank_row mismatches"}, mis, 0);
            chk(done == fin, {tag, " R7 done"}, done, fin);
            steps++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(fin, {tag, " R7 finished"}, fin, 1);
        chk(busy == 1'b0, {tag, " R7/R8 idle after done"}, busy, 0);
        chk(step_valid == 1'b0, {tag, " R2 no step when idle"}, step_valid, 0);
    endtask

    task automatic check_cycles(input int exp_cyc, input string tag);
        chk(exp_cyc == max_distinct(), {tag, " R6 table vs model"}, exp_cyc, max_distinct());
    endtask

    // capture cycles on the done step
    logic [CNT_W-1:0] last_cyc;
    always @(negedge clk) if (done) last_cyc <= cycles;

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && step_valid == 0 && done == 0, "R10 reset state",
            {busy, step_valid, done}, 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            for (int l = 0; l < NUM_LANES; l++)
                m_addr[l] = VEC[v][63:48] + ADDR_W'(l) * VEC[v][47:32];
            m_act = VEC[v][31:0];
            check_cycles(EXP_CYC[v], $sformatf("vec%0d", v));
            run_warp(EXP_CYC[v], -1, $sformatf("vec%0d", v));
            chk(int'(last_cyc) == EXP_CYC[v], $sformatf("vec%0d R6 cycles", v),
                last_cyc, EXP_CYC[v]);
            if (v == 8)
                chk(last_cyc == 0, "R9 empty warp cycles", last_cyc, 0);
        end

        // R4: lowest lane chooses the row in a contested bank
        for (int l = 0; l < NUM_LANES; l++) m_addr[l] = ADDR_W'(l * 4);
        m_addr[0] = 16'd128; m_addr[1] = 16'd0; m_addr[2] = 16'd1;
        m_act = 32'h0000_0007;
        run_warp(2, -1, "R4 prio");
        chk(last_cyc == 2, "R4 prio R6 cycles", last_cyc, 2);

        // R8: start while busy, mid-warp and on the done step
        for (int l = 0; l < NUM_LANES; l++) m_addr[l] = ADDR_W'(l * 256);
        m_act = 32'hFFFF_FFFF;
        run_warp(32, 3, "R8 mid");
        chk(last_cyc == 32, "R8 mid R6 cycles", last_cyc, 32);
        for (int l = 0; l < NUM_LANES; l++) m_addr[l] = ADDR_W'(l * 8);
        run_warp(2, 1, "R8 done-cycle");
        chk(last_cyc == 2, "R8 done-cycle R6 cycles", last_cyc, 2);

        // R10: reset in the middle of a warp returns to idle
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(busy == 0 && step_valid == 0 && done == 0, "R10 reset mid-warp",
            {busy, step_valid, done}, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        clk_cnt++;
        if (clk_cnt > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", clk_cnt);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule